// File: doc/BRIEF.md
# Fault-Tolerant Clock Correction Unit

This block produces one clock correction value per communication round for a node of a time-triggered, slot-scheduled cluster. While a round runs, it gathers signed timing deviations. Each deviation is the gap between the time a frame was expected and the time it actually arrived. A deviation is kept only when the sender is known to have a trustworthy oscillator. Exactly four deviations are used.

When the round-end pulse arrives, the four kept deviations are ranked by a compare-exchange network. The smallest and the largest are dropped. The two middle values are averaged, and the average is presented together with a one-cycle valid strobe. Dropping both extremes keeps the correction bounded even when one of the four deviations is arbitrarily wrong. If too few deviations were kept, the block reports a zero correction and flags that the round could not be used. Extra deviations beyond four are discarded and recorded in a sticky flag.

Top module: `ftm_clock_corr`

## Requirements
- R1: A deviation is captured only in a cycle where `dev_valid` and `dev_trusted` are both 1. A deviation with `dev_trusted` = 0 has no effect on any later result.
- R2: With four captured deviations sorted ascending as s0..s3, the correction is floor((s1 + s2) / 2). The sum is formed at 17 bits and shifted arithmetically right by one, so the result rounds toward negative infinity. The result does not depend on arrival order.
- R3: If any one of the four deviations takes an extreme value (-32768 or 32767), the correction still lies between the smallest and largest of the other three.
- R4: If fewer than four deviations were captured when the round closes, `corr_out` is 0 and `sync_short` is 1. With four captured, `sync_short` is 0.
- R5: `corr_valid` is 1 for exactly the one cycle after the cycle in which `round_end` is 1. Between round ends, `corr_out` and `sync_short` hold their values.
- R6: `round_end` empties the collection for the next round. A trusted deviation presented in the same cycle as `round_end` becomes the first deviation of the new round.
- R7: A trusted deviation arriving when four are already held (and `round_end` is 0) is discarded and sets `dev_overrun`. `dev_overrun` stays 1 until reset.
- R8: After reset, `corr_valid`, `corr_out`, `sync_short` and `dev_overrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_valid | input | 1 | A deviation is presented this cycle |
| dev_value | input | 16 | Signed two's-complement deviation |
| dev_trusted | input | 1 | Sender has an accurate oscillator |
| round_end | input | 1 | One-cycle round boundary pulse |
| corr_valid | output | 1 | One-cycle strobe for a new correction |
| corr_out | output | 16 | Signed correction term |
| sync_short | output | 1 | Last round had fewer than four deviations |
| dev_overrun | output | 1 | Sticky: a fifth trusted deviation was dropped |

## Verification
The bench feeds an extreme outlier at both ends of the range. A design that averaged all values, or kept the wrong pair from the sort, would let the correction jump toward the outlier. Odd negative sums are included, because a design that rounds toward zero or truncates the sum to 16 bits gives a value off by one, or with the wrong sign. The bench also sends an untrusted deviation, a short round, a fifth deviation, and a deviation in the same cycle as the round end. A design that counts untrusted deviations, overwrites a held value, forgets the sticky flag or loses the boundary deviation shows a wrong correction or wrong flags at the next strobe.

// File: rtl/ftm_pkg.sv
package ftm_pkg;
  // number of deviations ranked per round; the compare network is built for four
  localparam int unsigned FTM_NSAMP = 4;
  localparam int unsigned FTM_CNT_W = $clog2(FTM_NSAMP + 1);
endpackage

// File: rtl/ftm_collect.sv
module ftm_collect
  import ftm_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          take,
  input  logic [W-1:0]                  value,
  input  logic                          round_end,
  output logic [FTM_NSAMP-1:0][W-1:0]   slots,
  output logic                          full,
  output logic                          overrun
);
  localparam int unsigned CW = FTM_CNT_W;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] wr_idx;
  logic          accept;
  logic          ovr_q, ovr_d;
  logic [FTM_NSAMP-1:0][W-1:0] slot_q, slot_d;

  assign full   = (cnt_q == CW'(FTM_NSAMP));
  assign accept = take && (round_end || !full);
  assign wr_idx = round_end ? '0 : cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (round_end)   cnt_d = accept ? CW'(1) : '0;
    else if (accept) cnt_d = cnt_q + CW'(1);
    ovr_d = ovr_q | (take && !round_end && full);
  end

  for (genvar i = 0; i < FTM_NSAMP; i++) begin : g_slot
    logic wr_en;
    assign wr_en = accept && (wr_idx == CW'(i));
    always_comb begin
      slot_d[i] = slot_q[i];
      if (wr_en)          slot_d[i] = value;
      else if (round_end) slot_d[i] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ovr_q  <= 1'b0;
      slot_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      ovr_q  <= ovr_d;
      slot_q <= slot_d;
    end
  end

  assign slots   = slot_q;
  assign overrun = ovr_q;
endmodule

// File: rtl/ftm_cmpx.sv
module ftm_cmpx #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  logic swap;
  assign swap = $signed(a) > $signed(b);
  assign lo   = swap ? b : a;
  assign hi   = swap ? a : b;
endmodule

// File: rtl/ftm_sort4.sv
module ftm_sort4
  import ftm_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [FTM_NSAMP-1:0][W-1:0] din,
  output logic [FTM_NSAMP-1:0][W-1:0] dout
);
  // three stages: pairs, cross, middle
  logic [FTM_NSAMP-1:0][W-1:0] st1, st2;

  for (genvar p = 0; p < 2; p++) begin : g_stage1
    ftm_cmpx #(.W(W)) u_cx (
      .a(din[2*p]), .b(din[2*p+1]), .lo(st1[2*p]), .hi(st1[2*p+1])
    );
  end

  for (genvar p = 0; p < 2; p++) begin : g_stage2
    ftm_cmpx #(.W(W)) u_cx (
      .a(st1[p]), .b(st1[p+2]), .lo(st2[p]), .hi(st2[p+2])
    );
  end

  ftm_cmpx #(.W(W)) u_mid (
    .a(st2[1]), .b(st2[2]), .lo(dout[1]), .hi(dout[2])
  );
  assign dout[0] = st2[0];
  assign dout[3] = st2[3];
endmodule

// File: rtl/ftm_midpoint.sv
module ftm_midpoint #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] mid
);
  logic signed [W:0] sum;
  assign sum = $signed({lo[W-1], lo}) + $signed({hi[W-1], hi});
  // dropping the lsb of a two's-complement sum floors the halving
  assign mid = sum[W:1];
endmodule

// File: rtl/ftm_clock_corr.sv
module ftm_clock_corr
  import ftm_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dev_valid,
  input  logic [W-1:0] dev_value,
  input  logic         dev_trusted,
  input  logic         round_end,
  output logic         corr_valid,
  output logic [W-1:0] corr_out,
  output logic         sync_short,
  output logic         dev_overrun
);
  logic [FTM_NSAMP-1:0][W-1:0] slots, ranked;
  logic         full;
  logic [W-1:0] mid;

  ftm_collect #(.W(W)) u_collect (
    .clk(clk), .rst_n(rst_n),
    .take(dev_valid && dev_trusted), .value(dev_value),
    .round_end(round_end), .slots(slots), .full(full),
    .overrun(dev_overrun)
  );

  ftm_sort4 #(.W(W)) u_sort (.din(slots), .dout(ranked));

  ftm_midpoint #(.W(W)) u_mid (.lo(ranked[1]), .hi(ranked[2]), .mid(mid));

  logic         vld_q, vld_d;
  logic         short_q, short_d;
  logic [W-1:0] corr_q, corr_d;

  always_comb begin
    vld_d   = round_end;
    short_d = short_q;
    corr_d  = corr_q;
    if (round_end) begin
      short_d = !full;
      corr_d  = full ? mid : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      short_q <= 1'b0;
      corr_q  <= '0;
    end else begin
      vld_q   <= vld_d;
      short_q <= short_d;
      corr_q  <= corr_d;
    end
  end

  assign corr_valid = vld_q;
  assign sync_short = short_q;
  assign corr_out   = corr_q;
endmodule

// File: rtl/ftm_clock_corr_chk.sv
module ftm_clock_corr_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         round_end,
  input logic         corr_valid,
  input logic [W-1:0] corr_out,
  input logic         sync_short,
  input logic         dev_overrun
);
  // R5: strobe follows every round end
  a_r5_strobe_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    round_end |=> corr_valid);

  // R5: strobe only after a round end
  a_r5_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
    corr_valid |-> $past(round_end));

  // R5: outputs hold between round ends
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !round_end |=> ($stable(corr_out) && $stable(sync_short)));

  // R4: a short round reports zero correction
  a_r4_short_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_valid && sync_short) |-> (corr_out == '0));

  // R7: overrun flag is sticky
  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    dev_overrun |=> dev_overrun);
endmodule

bind ftm_clock_corr ftm_clock_corr_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .round_end(round_end),
  .corr_valid(corr_valid), .corr_out(corr_out),
  .sync_short(sync_short), .dev_overrun(dev_overrun)
);

// File: tb/ftm_clock_corr_bench.sv
module ftm_clock_corr_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dev_valid = 1'b0;
  logic [15:0] dev_value = '0;
  logic dev_trusted = 1'b0;
  logic round_end = 1'b0;
  logic corr_valid;
  logic [15:0] corr_out;
  logic sync_short;
  logic dev_overrun;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ftm_clock_corr u_ftm_clock_corr (
    .clk(clk), .rst_n(rst_n), .dev_valid(dev_valid), .dev_value(dev_value),
    .dev_trusted(dev_trusted), .round_end(round_end), .corr_valid(corr_valid),
    .corr_out(corr_out), .sync_short(sync_short), .dev_overrun(dev_overrun)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int mid4(input int a, input int b, input int c, input int d);
    int s[4];
    int t;
    s = '{a, b, c, d};
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 3 - i; j++)
        if (s[j] > s[j+1]) begin t = s[j]; s[j] = s[j+1]; s[j+1] = t; end
    t = s[1] + s[2];
    return t >>> 1;
  endfunction

  task automatic put(input int v, input logic trusted);
    @(negedge clk);
    dev_valid = 1'b1; dev_value = 16'(v); dev_trusted = trusted;
    @(negedge clk);
    dev_valid = 1'b0; dev_trusted = 1'b0;
  endtask

  // leaves time just after the edge that registered the result
  task automatic close_round();
    @(negedge clk); round_end = 1'b1;
    @(negedge clk); round_end = 1'b0;
  endtask

  task automatic full_round(input int a, input int b, input int c, input int d,
                            input string tag);
    put(a, 1); put(b, 1); put(c, 1); put(d, 1);
    close_round();
    chk({tag, " strobe"}, int'(corr_valid), 1);
    chk({tag, " short"}, int'(sync_short), 0);
    chk({tag, " corr"}, int'($signed(corr_out)), mid4(a, b, c, d));
  endtask

  task automatic t_reset();
    chk("R8 valid", int'(corr_valid), 0);
    chk("R8 corr", int'(corr_out), 0);
    chk("R8 short", int'(sync_short), 0);
    chk("R8 overrun", int'(dev_overrun), 0);
  endtask

  task automatic t_basic();
    full_round(10, 20, 30, 40, "R2 ascending");
    chk("R2 value", int'($signed(corr_out)), 25);
    full_round(40, 10, 30, 20, "R2 shuffled");
    full_round(-7, -4, -1, 9, "R2 floor");
    chk("R2 floor value", int'($signed(corr_out)), -3);
    full_round(32767, 32767, 32767, 32767, "R2 max");
    full_round(-32768, -32768, -32768, -32768, "R2 min");
  endtask

  task automatic t_outlier();
    full_round(100, 102, 32767, 104, "R3 high outlier");
    chk("R3 high value", int'($signed(corr_out)), 103);
    full_round(-32768, 100, 102, 104, "R3 low outlier");
    chk("R3 low value", int'($signed(corr_out)), 101);
  endtask

  task automatic t_untrusted();
    put(5, 1); put(6, 1); put(20000, 0); put(7, 1);
    close_round();
    chk("R1 short with untrusted", int'(sync_short), 1);
    chk("R4 zero corr", int'(corr_out), 0);
    put(5, 1); put(-30000, 0); put(6, 1); put(7, 1); put(8, 1);
    close_round();
    chk("R1 untrusted ignored", int'($signed(corr_out)), 6);
    chk("R1 short clear", int'(sync_short), 0);
  endtask

  task automatic t_empty();
    close_round();
    chk("R4 empty strobe", int'(corr_valid), 1);
    chk("R4 empty short", int'(sync_short), 1);
    chk("R4 empty corr", int'(corr_out), 0);
  endtask

  task automatic t_hold();
    full_round(1, 2, 3, 4, "R5 base");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R5 strobe low", int'(corr_valid), 0);
      chk("R5 corr held", int'($signed(corr_out)), 2);
    end
  endtask

  task automatic t_boundary();
    put(1, 1); put(2, 1); put(3, 1); put(4, 1);
    @(negedge clk);
    round_end = 1'b1; dev_valid = 1'b1; dev_trusted = 1'b1; dev_value = 16'd8;
    @(negedge clk);
    round_end = 1'b0; dev_valid = 1'b0; dev_trusted = 1'b0;
    chk("R6 closing round", int'($signed(corr_out)), 2);
    put(50, 1); put(60, 1); put(70, 1);
    close_round();
    chk("R6 carried short", int'(sync_short), 0);
    chk("R6 carried corr", int'($signed(corr_out)), 55);
    chk("R6 no overrun", int'(dev_overrun), 0);
  endtask

  task automatic t_overrun();
    put(10, 1); put(11, 1); put(12, 1); put(13, 1);
    chk("R7 before fifth", int'(dev_overrun), 0);
    put(30000, 1);
    chk("R7 flag set", int'(dev_overrun), 1);
    close_round();
    chk("R7 fifth ignored", int'($signed(corr_out)), 11);
    full_round(0, 2, 4, 6, "R7 next round");
    chk("R7 sticky", int'(dev_overrun), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_outlier();
    t_untrusted();
    t_empty();
    t_hold();
    t_boundary();
    t_overrun();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule